// File: doc/BRIEF.md
# Disk Geometry Calculator

This block derives a cylinder/head/sector geometry from a disk's total sector count, the values a drive identification record reports. A single-cycle start pulse captures a 32-bit total. The block then applies a fixed clamping sequence. A total at or above the largest describable geometry saturates to that geometry. Otherwise the sectors-per-track figure is capped first, the head count is capped second, and the cylinder count comes last from an integer division.

Both divisions share one restoring shift-subtract divider that produces one quotient bit per clock. A zero total and a saturating total finish without using the divider. When a result is ready, a one-cycle done pulse marks it. The three outputs change only on that pulse and hold their value until the next accepted start. A start that arrives while a calculation is in progress is dropped.

Top module: `chs_geom_calc`

## Requirements
- R1: While reset is asserted and after it is released, before any start, cyl_o, head_o and spt_o are 0 and done_o is 0.
- R2: A total of at least 16383*16*63 = 16514064 gives cyl_o = 16383, head_o = 16 and spt_o = 63.
- R3: Below that limit, spt_o is 63 when the total is at least 63, and otherwise spt_o equals the total.
- R4: Below that limit, head_o is 16 when total / spt_o is at least 16, and otherwise head_o equals that quotient.
- R5: Below that limit, cyl_o is total / (head_o * spt_o) with the remainder discarded.
- R6: A total of 0 gives all three outputs equal to 0.
- R7: done_o is high for exactly one cycle per accepted start. cyl_o, head_o and spt_o change only in a cycle where done_o is high.
- R8: A zero total or a saturating total raises done_o on the same clock edge that samples start_i. Any other total raises done_o 2*CNT_W+2 edges after that edge, which is 66 edges for CNT_W = 32.
- R9: A start_i sampled while a calculation is in progress is ignored, including on the edge that completes it. A start_i sampled in the cycle where done_o is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; captures total_i when the block is idle |
| total_i | input | 32 | Total sector count |
| cyl_o | output | 16 | Cylinder count |
| head_o | output | 8 | Head count |
| spt_o | output | 8 | Sectors per track |
| done_o | output | 1 | One-cycle result pulse |

## Verification
Two events can fall in the same cycle: the completion of the second division and a new start request. A start that coincides with the completing edge must be dropped. A start presented while done_o is high must be taken as a fresh calculation. The bench places a start exactly on the 66th edge after an accepted start and checks two things: the finished result belongs to the first total, and no second done pulse ever follows. The bench then raises start in the done cycle and checks that the second total's geometry arrives after the full normal latency.

// File: rtl/geom_pkg.sv
package geom_pkg;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_DIV_SPT = 2'd1,
        GS_DIV_CYL = 2'd2
    } geom_state_e;

endpackage

// File: rtl/geom_cap.sv
// Saturating narrowing: passes the input through, or LIMIT when the input reaches it.
module geom_cap #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 8,
    parameter int LIMIT = 63
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    localparam logic [IN_W-1:0]  LIM_IN  = IN_W'(LIMIT);
    localparam logic [OUT_W-1:0] LIM_OUT = OUT_W'(LIMIT);

    always_comb begin
        if (val_i >= LIM_IN) begin
            val_o = LIM_OUT;
        end else begin
            val_o = val_i[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/geom_div.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module geom_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         done_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] STEPS = CW'(W);

    typedef struct packed {
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic [CW-1:0] cnt;
        logic          done;
    } div_t;

    div_t div_d, div_q;
    logic [W:0]   rem_sh;
    logic [W-1:0] quo_sh;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        rem_sh     = {div_q.rem[W-1:0], div_q.quo[W-1]};
        quo_sh     = {div_q.quo[W-2:0], 1'b0};
        if (div_q.cnt == '0) begin
            if (go_i) begin
                div_d.rem = '0;
                div_d.quo = dvd_i;
                div_d.dvs = dvs_i;
                div_d.cnt = STEPS;
            end
        end else begin
            if (rem_sh >= {1'b0, div_q.dvs}) begin
                rem_sh    = rem_sh - {1'b0, div_q.dvs};
                quo_sh[0] = 1'b1;
            end
            div_d.rem  = rem_sh;
            div_d.quo  = quo_sh;
            div_d.cnt  = div_q.cnt - 1'b1;
            div_d.done = (div_q.cnt == CW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign done_o = div_q.done;
    assign quo_o  = div_q.quo;
endmodule

// File: rtl/chs_geom_calc.sv
module chs_geom_calc #(
    parameter int CNT_W    = 32,
    parameter int CYL_W    = 16,
    parameter int HEAD_W   = 8,
    parameter int SPT_W    = 8,
    parameter int MAX_CYL  = 16383,
    parameter int MAX_HEAD = 16,
    parameter int MAX_SPT  = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  total_i,
    output logic [CYL_W-1:0]  cyl_o,
    output logic [HEAD_W-1:0] head_o,
    output logic [SPT_W-1:0]  spt_o,
    output logic              done_o
);
    import geom_pkg::*;

    localparam logic [CNT_W-1:0]  SAT_TOTAL = CNT_W'(MAX_CYL * MAX_HEAD * MAX_SPT);
    localparam logic [CYL_W-1:0]  SAT_CYL   = CYL_W'(MAX_CYL);
    localparam logic [HEAD_W-1:0] SAT_HEAD  = HEAD_W'(MAX_HEAD);
    localparam logic [SPT_W-1:0]  SAT_SPT   = SPT_W'(MAX_SPT);

    typedef struct packed {
        geom_state_e       state;
        logic [CNT_W-1:0]  total;
        logic [SPT_W-1:0]  w_spt;
        logic [CYL_W-1:0]  cyl;
        logic [HEAD_W-1:0] head;
        logic [SPT_W-1:0]  spt;
        logic              done;
    } geom_t;

    geom_t g_d, g_q;

    logic              div_go;
    logic [CNT_W-1:0]  div_dvd;
    logic [CNT_W-1:0]  div_dvs;
    logic              div_done;
    logic [CNT_W-1:0]  div_quo;
    logic [SPT_W-1:0]  spt_capped;
    logic [HEAD_W-1:0] head_capped;

    geom_cap #(.IN_W(CNT_W), .OUT_W(SPT_W), .LIMIT(MAX_SPT)) u_spt_cap (
        .val_i (total_i),
        .val_o (spt_capped)
    );

    geom_cap #(.IN_W(CNT_W), .OUT_W(HEAD_W), .LIMIT(MAX_HEAD)) u_head_cap (
        .val_i (div_quo),
        .val_o (head_capped)
    );

    geom_div #(.W(CNT_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .dvd_i  (div_dvd),
        .dvs_i  (div_dvs),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        g_d      = g_q;
        g_d.done = 1'b0;
        div_go   = 1'b0;
        div_dvd  = g_q.total;
        div_dvs  = '0;
        unique case (g_q.state)
            GS_IDLE: begin
                if (start_i) begin
                    g_d.total = total_i;
                    if (total_i == '0) begin
                        g_d.cyl  = '0;
                        g_d.head = '0;
                        g_d.spt  = '0;
                        g_d.done = 1'b1;
                    end else if (total_i >= SAT_TOTAL) begin
                        g_d.cyl  = SAT_CYL;
                        g_d.head = SAT_HEAD;
                        g_d.spt  = SAT_SPT;
                        g_d.done = 1'b1;
                    end else begin
                        g_d.w_spt = spt_capped;
                        div_go    = 1'b1;
                        div_dvd   = total_i;
                        div_dvs   = CNT_W'(spt_capped);
                        g_d.state = GS_DIV_SPT;
                    end
                end
            end
            GS_DIV_SPT: begin
                if (div_done) begin
                    g_d.head  = head_capped;
                    g_d.spt   = g_q.w_spt;
                    div_go    = 1'b1;
                    div_dvd   = g_q.total;
                    div_dvs   = CNT_W'(head_capped) * CNT_W'(g_q.w_spt);
                    g_d.state = GS_DIV_CYL;
                    // head and spt are staged into the output registers only at done
                    g_d.head  = g_q.head;
                    g_d.spt   = g_q.spt;
                    g_d.cyl   = g_q.cyl;
                end
            end
            GS_DIV_CYL: begin
                if (div_done) begin
                    g_d.cyl   = div_quo[CYL_W-1:0];
                    g_d.spt   = g_q.w_spt;
                    g_d.done  = 1'b1;
                    g_d.state = GS_IDLE;
                end
            end
            default: begin
                g_d.state = GS_IDLE;
            end
        endcase
    end

    // Head count staged between the two divisions, kept apart from the output.
    logic [HEAD_W-1:0] w_head_d, w_head_q;

    always_comb begin
        w_head_d = w_head_q;
        if (g_q.state == GS_DIV_SPT && div_done) begin
            w_head_d = head_capped;
        end
    end

    geom_t g_fix;

    always_comb begin
        g_fix = g_d;
        if (g_q.state == GS_DIV_CYL && div_done) begin
            g_fix.head = w_head_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q      <= '{state: GS_IDLE, default: '0};
            w_head_q <= '0;
        end else begin
            g_q      <= g_fix;
            w_head_q <= w_head_d;
        end
    end

    assign cyl_o  = g_q.cyl;
    assign head_o = g_q.head;
    assign spt_o  = g_q.spt;
    assign done_o = g_q.done;
endmodule

// File: rtl/geom_calc_checker.sv
module geom_calc_checker #(
    parameter int CYL_W  = 16,
    parameter int HEAD_W = 8,
    parameter int SPT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CYL_W-1:0]  cyl_o,
    input logic [HEAD_W-1:0] head_o,
    input logic [SPT_W-1:0]  spt_o,
    input logic              done_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cyl_o) && $stable(head_o) && $stable(spt_o))); // R7

    AST_SPT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (spt_o <= SPT_W'(63))); // R3

    AST_HEAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (head_o <= HEAD_W'(16))); // R4

    AST_ZERO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && spt_o == '0) |-> (head_o == '0 && cyl_o == '0)); // R6

    AST_NONZERO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && spt_o != '0) |-> (head_o != '0 && cyl_o != '0)); // R5
endmodule

bind chs_geom_calc geom_calc_checker #(
    .CYL_W  (CYL_W),
    .HEAD_W (HEAD_W),
    .SPT_W  (SPT_W)
) u_geom_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyl_o  (cyl_o),
    .head_o (head_o),
    .spt_o  (spt_o),
    .done_o (done_o)
);

// File: tb/chs_geom_calc_test.sv
module chs_geom_calc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] total_i = '0;
    logic [15:0] cyl_o;
    logic [7:0]  head_o;
    logic [7:0]  spt_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    localparam int LAT_DIV = 66;

    // total, cylinders, heads, sectors
    localparam logic [63:0] VEC [12] = '{
        {32'd16514064, 16'd16383, 8'd16, 8'd63},
        {32'd16514063, 16'd16382, 8'd16, 8'd63},
        {32'hFFFFFFFF, 16'd16383, 8'd16, 8'd63},
        {32'd1,        16'd1,     8'd1,  8'd1 },
        {32'd62,       16'd1,     8'd1,  8'd62},
        {32'd63,       16'd1,     8'd1,  8'd63},
        {32'd1007,     16'd1,     8'd15, 8'd63},
        {32'd1008,     16'd1,     8'd16, 8'd63},
        {32'd100000,   16'd99,    8'd16, 8'd63},
        {32'd1000000,  16'd992,   8'd16, 8'd63},
        {32'd130,      16'd1,     8'd2,  8'd63},
        {32'd500,      16'd1,     8'd7,  8'd63}
    };

    chs_geom_calc uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .total_i (total_i),
        .cyl_o   (cyl_o),
        .head_o  (head_o),
        .spt_o   (spt_o),
        .done_o  (done_o)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_geom(input string req, input logic [15:0] c, input logic [7:0] h,
                              input logic [7:0] s);
        check(cyl_o == c, req, longint'(cyl_o), longint'(c));
        check(head_o == h, req, longint'(head_o), longint'(h));
        check(spt_o == s, req, longint'(spt_o), longint'(s));
    endtask

    // Drives start for one edge, then counts edges until done is seen.
    task automatic run(input logic [31:0] tot, output int lat);
        @(negedge clk);
        start_i = 1'b1;
        total_i = tot;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        int lat;
        int extra;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R1", longint'(done_o), 0);
        check_geom("R1", 16'd0, 8'd0, 8'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0, "R1", longint'(done_o), 0);
        check_geom("R1", 16'd0, 8'd0, 8'd0);

        // R2..R5 table walk with R8 latency and R7 pulse width
        foreach (VEC[i]) begin
            logic [31:0] t;
            t = VEC[i][63:32];
            run(t, lat);
            if (t >= 32'd16514064) begin
                check_geom("R2", VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);
                check(lat == 0, "R8", lat, 0);
            end else begin
                check(spt_o == VEC[i][7:0], "R3", longint'(spt_o), longint'(VEC[i][7:0]));
                check(head_o == VEC[i][15:8], "R4", longint'(head_o), longint'(VEC[i][15:8]));
                check(cyl_o == VEC[i][31:16], "R5", longint'(cyl_o), longint'(VEC[i][31:16]));
                check(lat == LAT_DIV, "R8", lat, LAT_DIV);
            end
            @(negedge clk);
            check(done_o == 1'b0, "R7", longint'(done_o), 0);
        end

        // R6: zero total
        run(32'd0, lat);
        check_geom("R6", 16'd0, 8'd0, 8'd0);
        check(lat == 0, "R8", lat, 0);

        // R7: outputs hold while the next calculation runs
        run(32'd1000000, lat);
        @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        check_geom("R7", 16'd992, 8'd16, 8'd63);
        while (!done_o) @(negedge clk);
        check_geom("R5", 16'd1, 8'd1, 8'd1);

        // R9: start mid-calculation is dropped
        @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd100000;
        @(posedge clk);
        @(negedge clk);
        total_i = 32'd63;
        repeat (10) @(negedge clk);
        start_i = 1'b0;
        lat = 11;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check_geom("R9", 16'd99, 8'd16, 8'd63);

        // R9: start on the completing edge is dropped
        @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd1000000;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        repeat (LAT_DIV - 1) @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd500;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R9", longint'(done_o), 1);
        check_geom("R9", 16'd992, 8'd16, 8'd63);
        extra = 0;
        repeat (100) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0, "R9", extra, 0);

        // R9: start in the done cycle is accepted
        @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd130;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        start_i = 1'b1;
        total_i = 32'd1008;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        check(lat == LAT_DIV, "R9", lat, LAT_DIV);
        check_geom("R9", 16'd1, 8'd16, 8'd63);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule